// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block belongs to a five-stage in-order integer pipeline. It chooses the two operand values that reach the ALU in the execute stage. Each operand's register number, held in the decode/execute pipeline register, is compared with the destination register of the instruction one stage ahead, in the execute/memory register, and with the destination of the instruction two stages ahead, in the memory/writeback register. If an older instruction is about to write that register, its result goes to the ALU in place of the register-file value that was read earlier. Each operand has its own multiplexer, and a 2-bit select code drives it.

All registers in the pipeline are clocked on the rising edge only. The register file therefore cannot write in one half-cycle and read in the other. To cover this, the block also has a write-through path on the two decode-stage read ports. When decode reads the register that writeback is writing in the same cycle, the read returns the new write data.

The unit is purely combinational. Stall detection and branch resolution are handled elsewhere.

Top module: `fwd_unit`

## Requirements
- R1: When neither later stage forwards to an operand, that operand's select code is 2'b00 and the operand equals the register-file value carried in the decode/execute register.
- R2: When the execute/memory stage has its write enable set and its destination is a nonzero register equal to the operand's source, the select code is 2'b10 and the operand equals the execute/memory ALU result.
- R3: When only the memory/writeback stage forwards to an operand (write enable set, nonzero destination equal to the source), the select code is 2'b01 and the operand equals the writeback value.
- R4: When both later stages would forward to the same operand, the execute/memory stage takes priority (select 2'b10), because it holds the younger result.
- R5: A destination of register 0 never causes a forward or a decode write-through, even with write enable set.
- R6: A stage whose write enable is clear never causes a forward or a decode write-through, even when its register numbers match.
- R7: The writeback value is the load data when the memory-to-register flag is 1 and the ALU result when it is 0. It appears on `wb_data` and is the value used by every forward and write-through from writeback.
- R8: A decode read port whose index equals a nonzero writeback destination, with writeback enabled, returns the writeback value. Otherwise it returns the raw register-file read data.
- R9: The two operands are selected independently. One operand's match has no effect on the other operand's select code or value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_idx | input | IDXW | First source register number in decode/execute |
| ex_rt_idx | input | IDXW | Second source register number in decode/execute |
| ex_rs_val | input | XLEN | Register-file value for the first source |
| ex_rt_val | input | XLEN | Register-file value for the second source |
| mem_wr_en | input | 1 | Register write enable of the execute/memory stage |
| mem_rd_idx | input | IDXW | Destination register of the execute/memory stage |
| mem_alu_res | input | XLEN | ALU result held in execute/memory |
| wb_wr_en | input | 1 | Register write enable of the memory/writeback stage |
| wb_rd_idx | input | IDXW | Destination register of the memory/writeback stage |
| wb_mem_to_reg | input | 1 | 1 selects load data as the writeback value |
| wb_alu_res | input | XLEN | ALU result held in memory/writeback |
| wb_load_data | input | XLEN | Load data held in memory/writeback |
| id_rs_idx | input | IDXW | Decode read port 0 register number |
| id_rt_idx | input | IDXW | Decode read port 1 register number |
| id_rs_raw | input | XLEN | Raw register-file data on read port 0 |
| id_rt_raw | input | XLEN | Raw register-file data on read port 1 |
| sel_a | output | 2 | Select code of the first ALU operand multiplexer |
| sel_b | output | 2 | Select code of the second ALU operand multiplexer |
| opnd_a | output | XLEN | First forwarded ALU operand |
| opnd_b | output | XLEN | Second forwarded ALU operand |
| id_rs_val | output | XLEN | Read port 0 value after write-through |
| id_rt_val | output | XLEN | Read port 1 value after write-through |
| wb_data | output | XLEN | Writeback value |

## Verification
Directed patterns come first. They cover a match from the execute/memory stage alone, a match from writeback alone, a match from both stages at once, and a match on only one of the two operands. This separates the choice of source, the priority order and the independence of the two operands. Matches against register 0, and matches from a stage whose write enable is clear, show that the qualifying conditions are applied. Patterns that toggle the memory-to-register flag separate load data from the ALU result on the writeback path. Long random runs then draw register numbers from a small range so that matches happen often, and compare every output with a behavioural reference model each cycle.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int unsigned XLEN_DEF = 32;
    localparam int unsigned NREG_DEF = 32;

    // Operand source select codes; the multiplexer decodes these values.
    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_WB  = 2'b01,
        SRC_MEM = 2'b10
    } fwd_src_e;

    // A producing stage qualifies when it writes, is not register 0,
    // and targets the consumer's source register.
    function automatic logic prod_hit(
        input logic        en,
        input logic [15:0] dst,
        input logic [15:0] src
    );
        return en && (dst != '0) && (dst == src);
    endfunction

endpackage

// File: rtl/fwd_wb_sel.sv
module fwd_wb_sel #(
    parameter int unsigned XLEN = fwd_pkg::XLEN_DEF
) (
    input  logic            mem_to_reg,
    input  logic [XLEN-1:0] alu_res,
    input  logic [XLEN-1:0] load_data,
    output logic [XLEN-1:0] wb_val
);
    always_comb begin
        if (mem_to_reg) wb_val = load_data;
        else            wb_val = alu_res;
    end
endmodule

// File: rtl/fwd_src_pick.sv
module fwd_src_pick
    import fwd_pkg::*;
#(
    parameter int unsigned IDXW = 5
) (
    input  logic [IDXW-1:0] src_idx,
    input  logic            mem_en,
    input  logic [IDXW-1:0] mem_idx,
    input  logic            wb_en,
    input  logic [IDXW-1:0] wb_idx,
    output fwd_src_e        src_sel
);
    logic [15:0] src_w, mem_w, wb_w;
    logic        mem_hit, wb_hit;

    always_comb begin
        src_w = 16'(src_idx);
        mem_w = 16'(mem_idx);
        wb_w  = 16'(wb_idx);
        mem_hit = prod_hit(mem_en, mem_w, src_w);
        wb_hit  = prod_hit(wb_en, wb_w, src_w);
        // Younger producer wins.
        if (mem_hit)     src_sel = SRC_MEM;
        else if (wb_hit) src_sel = SRC_WB;
        else             src_sel = SRC_RF;
    end
endmodule

// File: rtl/fwd_opnd_mux.sv
module fwd_opnd_mux
    import fwd_pkg::*;
#(
    parameter int unsigned XLEN = fwd_pkg::XLEN_DEF
) (
    input  fwd_src_e        sel,
    input  logic [XLEN-1:0] rf_val,
    input  logic [XLEN-1:0] mem_val,
    input  logic [XLEN-1:0] wb_val,
    output logic [XLEN-1:0] opnd
);
    always_comb begin
        unique case (sel)
            SRC_MEM: opnd = mem_val;
            SRC_WB:  opnd = wb_val;
            default: opnd = rf_val;
        endcase
    end
endmodule

// File: rtl/rf_rd_bypass.sv
module rf_rd_bypass
    import fwd_pkg::*;
#(
    parameter int unsigned XLEN = fwd_pkg::XLEN_DEF,
    parameter int unsigned IDXW = 5
) (
    input  logic [IDXW-1:0] rd_idx,
    input  logic [XLEN-1:0] raw_val,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] rd_val
);
    always_comb begin
        if (prod_hit(wr_en, 16'(wr_idx), 16'(rd_idx))) rd_val = wr_data;
        else                                          rd_val = raw_val;
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int unsigned XLEN = fwd_pkg::XLEN_DEF,
    parameter int unsigned NREG = fwd_pkg::NREG_DEF,
    localparam int unsigned IDXW = $clog2(NREG)
) (
    input  logic [IDXW-1:0] ex_rs_idx,
    input  logic [IDXW-1:0] ex_rt_idx,
    input  logic [XLEN-1:0] ex_rs_val,
    input  logic [XLEN-1:0] ex_rt_val,
    input  logic            mem_wr_en,
    input  logic [IDXW-1:0] mem_rd_idx,
    input  logic [XLEN-1:0] mem_alu_res,
    input  logic            wb_wr_en,
    input  logic [IDXW-1:0] wb_rd_idx,
    input  logic            wb_mem_to_reg,
    input  logic [XLEN-1:0] wb_alu_res,
    input  logic [XLEN-1:0] wb_load_data,
    input  logic [IDXW-1:0] id_rs_idx,
    input  logic [IDXW-1:0] id_rt_idx,
    input  logic [XLEN-1:0] id_rs_raw,
    input  logic [XLEN-1:0] id_rt_raw,
    output logic [1:0]      sel_a,
    output logic [1:0]      sel_b,
    output logic [XLEN-1:0] opnd_a,
    output logic [XLEN-1:0] opnd_b,
    output logic [XLEN-1:0] id_rs_val,
    output logic [XLEN-1:0] id_rt_val,
    output logic [XLEN-1:0] wb_data
);
    localparam int unsigned NPORT = 2;

    logic [XLEN-1:0] wb_val;
    logic [IDXW-1:0] ex_idx  [NPORT];
    logic [XLEN-1:0] ex_rf   [NPORT];
    logic [XLEN-1:0] ex_out  [NPORT];
    fwd_src_e        ex_sel  [NPORT];
    logic [IDXW-1:0] id_idx  [NPORT];
    logic [XLEN-1:0] id_raw  [NPORT];
    logic [XLEN-1:0] id_out  [NPORT];

    assign ex_idx[0] = ex_rs_idx;
    assign ex_idx[1] = ex_rt_idx;
    assign ex_rf[0]  = ex_rs_val;
    assign ex_rf[1]  = ex_rt_val;
    assign id_idx[0] = id_rs_idx;
    assign id_idx[1] = id_rt_idx;
    assign id_raw[0] = id_rs_raw;
    assign id_raw[1] = id_rt_raw;

    fwd_wb_sel #(.XLEN(XLEN)) u_wb_sel (
        .mem_to_reg (wb_mem_to_reg),
        .alu_res    (wb_alu_res),
        .load_data  (wb_load_data),
        .wb_val     (wb_val)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        fwd_src_pick #(.IDXW(IDXW)) u_pick (
            .src_idx (ex_idx[p]),
            .mem_en  (mem_wr_en),
            .mem_idx (mem_rd_idx),
            .wb_en   (wb_wr_en),
            .wb_idx  (wb_rd_idx),
            .src_sel (ex_sel[p])
        );

        fwd_opnd_mux #(.XLEN(XLEN)) u_mux (
            .sel     (ex_sel[p]),
            .rf_val  (ex_rf[p]),
            .mem_val (mem_alu_res),
            .wb_val  (wb_val),
            .opnd    (ex_out[p])
        );

        rf_rd_bypass #(.XLEN(XLEN), .IDXW(IDXW)) u_rdbyp (
            .rd_idx  (id_idx[p]),
            .raw_val (id_raw[p]),
            .wr_en   (wb_wr_en),
            .wr_idx  (wb_rd_idx),
            .wr_data (wb_val),
            .rd_val  (id_out[p])
        );
    end

    assign sel_a     = ex_sel[0];
    assign sel_b     = ex_sel[1];
    assign opnd_a    = ex_out[0];
    assign opnd_b    = ex_out[1];
    assign id_rs_val = id_out[0];
    assign id_rt_val = id_out[1];
    assign wb_data   = wb_val;
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned IDXW = 5
) (
    input logic [IDXW-1:0] ex_rs_idx,
    input logic [IDXW-1:0] ex_rt_idx,
    input logic [XLEN-1:0] ex_rs_val,
    input logic            mem_wr_en,
    input logic [IDXW-1:0] mem_rd_idx,
    input logic [XLEN-1:0] mem_alu_res,
    input logic            wb_wr_en,
    input logic [IDXW-1:0] wb_rd_idx,
    input logic            wb_mem_to_reg,
    input logic [XLEN-1:0] wb_alu_res,
    input logic [XLEN-1:0] wb_load_data,
    input logic [IDXW-1:0] id_rs_idx,
    input logic [XLEN-1:0] id_rs_raw,
    input logic [1:0]      sel_a,
    input logic [1:0]      sel_b,
    input logic [XLEN-1:0] opnd_a,
    input logic [XLEN-1:0] id_rs_val,
    input logic [XLEN-1:0] wb_data
);
    always_comb begin
        if (!$isunknown({ex_rs_idx, ex_rt_idx, mem_wr_en, mem_rd_idx,
                         wb_wr_en, wb_rd_idx, wb_mem_to_reg, id_rs_idx})) begin
            // R1
            a_r1_rf_path: assert (sel_a != 2'b00 || opnd_a == ex_rs_val);
            // R2
            a_r2_mem_value: assert (sel_a != 2'b10 || opnd_a == mem_alu_res);
            // R4
            a_r4_mem_priority: assert (!(mem_wr_en && wb_wr_en && mem_rd_idx != '0
                && mem_rd_idx == ex_rs_idx && wb_rd_idx == ex_rs_idx) || sel_a == 2'b10);
            // R5
            a_r5_zero_never: assert (ex_rs_idx != '0 || sel_a == 2'b00);
            // R6
            a_r6_disabled_never: assert (mem_wr_en || wb_wr_en
                || (sel_a == 2'b00 && sel_b == 2'b00));
            // R7
            a_r7_wb_choice: assert (wb_data == (wb_mem_to_reg ? wb_load_data : wb_alu_res));
            // R8
            a_r8_writethrough: assert (!(wb_wr_en && wb_rd_idx != '0 && wb_rd_idx == id_rs_idx)
                || id_rs_val == wb_data);
            a_r8_raw_read: assert ((wb_wr_en && wb_rd_idx != '0 && wb_rd_idx == id_rs_idx)
                || id_rs_val == id_rs_raw);
        end
    end
endmodule

bind fwd_unit fwd_unit_chk #(.XLEN(XLEN), .IDXW(IDXW)) u_chk (
    .ex_rs_idx     (ex_rs_idx),
    .ex_rt_idx     (ex_rt_idx),
    .ex_rs_val     (ex_rs_val),
    .mem_wr_en     (mem_wr_en),
    .mem_rd_idx    (mem_rd_idx),
    .mem_alu_res   (mem_alu_res),
    .wb_wr_en      (wb_wr_en),
    .wb_rd_idx     (wb_rd_idx),
    .wb_mem_to_reg (wb_mem_to_reg),
    .wb_alu_res    (wb_alu_res),
    .wb_load_data  (wb_load_data),
    .id_rs_idx     (id_rs_idx),
    .id_rs_raw     (id_rs_raw),
    .sel_a         (sel_a),
    .sel_b         (sel_b),
    .opnd_a        (opnd_a),
    .id_rs_val     (id_rs_val),
    .wb_data       (wb_data)
);

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;
    localparam int XLEN = 32;
    localparam int IDXW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [IDXW-1:0] ex_rs_idx, ex_rt_idx, mem_rd_idx, wb_rd_idx, id_rs_idx, id_rt_idx;
    logic [XLEN-1:0] ex_rs_val, ex_rt_val, mem_alu_res, wb_alu_res, wb_load_data;
    logic [XLEN-1:0] id_rs_raw, id_rt_raw;
    logic            mem_wr_en, wb_wr_en, wb_mem_to_reg;
    logic [1:0]      sel_a, sel_b;
    logic [XLEN-1:0] opnd_a, opnd_b, id_rs_val, id_rt_val, wb_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    fwd_unit u_dut (
        .ex_rs_idx(ex_rs_idx), .ex_rt_idx(ex_rt_idx),
        .ex_rs_val(ex_rs_val), .ex_rt_val(ex_rt_val),
        .mem_wr_en(mem_wr_en), .mem_rd_idx(mem_rd_idx), .mem_alu_res(mem_alu_res),
        .wb_wr_en(wb_wr_en), .wb_rd_idx(wb_rd_idx), .wb_mem_to_reg(wb_mem_to_reg),
        .wb_alu_res(wb_alu_res), .wb_load_data(wb_load_data),
        .id_rs_idx(id_rs_idx), .id_rt_idx(id_rt_idx),
        .id_rs_raw(id_rs_raw), .id_rt_raw(id_rt_raw),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .id_rs_val(id_rs_val), .id_rt_val(id_rt_val), .wb_data(wb_data)
    );

    task automatic check(input string req, input string what,
                         input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: which source feeds an operand.
    function automatic int ref_src(input int src);
        if (mem_wr_en && mem_rd_idx != 0 && int'(mem_rd_idx) == src) return 2;
        if (wb_wr_en && wb_rd_idx != 0 && int'(wb_rd_idx) == src) return 1;
        return 0;
    endfunction

    function automatic string ref_tag(input int src);
        bit m = mem_wr_en && mem_rd_idx != 0 && int'(mem_rd_idx) == src;
        bit w = wb_wr_en && wb_rd_idx != 0 && int'(wb_rd_idx) == src;
        if (m && w) return "R4";
        if (m)      return "R2";
        if (w)      return "R3";
        if (src == 0) return "R5";
        if ((int'(mem_rd_idx) == src && !mem_wr_en) || (int'(wb_rd_idx) == src && !wb_wr_en))
            return "R6";
        return "R1";
    endfunction

    task automatic compare_all();
        logic [XLEN-1:0] wbv, ea, eb;
        int sa, sb;
        wbv = wb_mem_to_reg ? wb_load_data : wb_alu_res;
        sa  = ref_src(int'(ex_rs_idx));
        sb  = ref_src(int'(ex_rt_idx));
        ea  = (sa == 2) ? mem_alu_res : (sa == 1) ? wbv : ex_rs_val;
        eb  = (sb == 2) ? mem_alu_res : (sb == 1) ? wbv : ex_rt_val;
        check("R7", "wb_data", wb_data, wbv);
        check(ref_tag(int'(ex_rs_idx)), "sel_a", XLEN'(sel_a), XLEN'(sa));
        check(ref_tag(int'(ex_rs_idx)), "opnd_a", opnd_a, ea);
        check("R9", "sel_b", XLEN'(sel_b), XLEN'(sb));
        check("R9", "opnd_b", opnd_b, eb);
        check("R8", "id_rs_val", id_rs_val,
              (wb_wr_en && wb_rd_idx != 0 && wb_rd_idx == id_rs_idx) ? wbv : id_rs_raw);
        check("R8", "id_rt_val", id_rt_val,
              (wb_wr_en && wb_rd_idx != 0 && wb_rd_idx == id_rt_idx) ? wbv : id_rt_raw);
    endtask

    task automatic drive(input int rs, input int rt, input bit me, input int md,
                         input bit we, input int wd, input bit m2r);
        @(posedge clk);
        ex_rs_idx = IDXW'(rs); ex_rt_idx = IDXW'(rt);
        mem_wr_en = me; mem_rd_idx = IDXW'(md);
        wb_wr_en = we; wb_rd_idx = IDXW'(wd); wb_mem_to_reg = m2r;
        id_rs_idx = IDXW'(rs); id_rt_idx = IDXW'(rt);
        ex_rs_val = $urandom; ex_rt_val = $urandom;
        mem_alu_res = $urandom; wb_alu_res = $urandom; wb_load_data = $urandom;
        id_rs_raw = $urandom; id_rt_raw = $urandom;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        ex_rs_idx = '0; ex_rt_idx = '0; mem_wr_en = 1'b0; mem_rd_idx = '0;
        wb_wr_en = 1'b0; wb_rd_idx = '0; wb_mem_to_reg = 1'b0;
        id_rs_idx = '0; id_rt_idx = '0;
        ex_rs_val = 32'h1111_0000; ex_rt_val = 32'h2222_0000;
        mem_alu_res = 32'hAAAA_0001; wb_alu_res = 32'hBBBB_0002; wb_load_data = 32'hCCCC_0003;
        id_rs_raw = 32'h3333_0000; id_rt_raw = 32'h4444_0000;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle state passes register-file values through
        check("R1", "idle sel_a", XLEN'(sel_a), '0);
        check("R1", "idle opnd_a", opnd_a, 32'h1111_0000);

        drive(3, 4, 1, 3, 0, 0, 0);   // R2 on A only, R9 B untouched
        drive(5, 6, 0, 0, 1, 6, 0);   // R3 on B, ALU result
        drive(5, 6, 0, 0, 1, 5, 1);   // R3 on A, R7 load data
        drive(7, 7, 1, 7, 1, 7, 1);   // R4 both operands
        drive(0, 0, 1, 0, 1, 0, 1);   // R5 register 0
        drive(8, 9, 0, 8, 0, 9, 0);   // R6 matches but disabled
        drive(2, 2, 0, 0, 1, 2, 0);   // R8 write-through on both ports
        drive(2, 3, 1, 3, 1, 2, 1);   // A from WB, B from MEM

        for (int i = 0; i < 3000; i++) begin
            drive($urandom_range(0, 3), $urandom_range(0, 3),
                  1'($urandom), $urandom_range(0, 3),
                  1'($urandom), $urandom_range(0, 3), 1'($urandom));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule